// File: doc/BRIEF.md
# Trailing Bit Mask Unit

A registered 64-bit functional unit that derives masks from the lowest clear bit or the lowest set bit of an operand. A 4-bit operation code picks one of nine transforms. Each one combines the operand, its wrapped increment or decrement, and the complement through AND, OR and XOR. One cycle later the result comes out, with two flags. One flag shows that the operand had no qualifying bit: no clear bit for the increment-based transforms, or no set bit for the decrement-based ones. The other flag shows an unused operation code.

A datapath issues one operand with a valid strobe and gets the answer, also strobed, on the next cycle. Outputs keep their last value while no new operand is offered. Operands made entirely of ones, or entirely of zeros, have defined results. All arithmetic wraps modulo 2^64.

Top module: `trailbit_unit`

## Requirements
- R1: Latency is one cycle. `res_valid` equals the `op_valid` of the previous cycle. A synchronous reset drives `res_valid`, `res_data`, `res_nobit` and `res_badop` to zero.
- R2: Codes 0, 1 and 2 give `x & (x+1)` (clear the trailing ones), `x | ~(x+1)` (all ones except the lowest clear bit) and `~x & (x+1)` (one-hot of the lowest clear bit). Example: 0x57 under code 0 gives 0x50, and 0x51 under code 2 gives 0x2.
- R3: Code 3 gives `x ^ (x+1)`, a mask up to and including the lowest clear bit. Code 4 gives `x | (x+1)`, which sets the lowest clear bit.
- R4: Code 5 gives `x | (x-1)`, which fills the zeros below the lowest set bit. Code 6 gives `~x | (x-1)`, all ones except the lowest set bit.
- R5: Code 7 gives `~x | (x+1)`, which zeroes the trailing ones and sets every other bit. Code 8 gives `~x & (x-1)`, a mask of the trailing zeros. Example: 0x58 under code 8 gives 0x7.
- R6: Increments and decrements wrap modulo 2^64. For an all-ones operand, codes 0, 2 and 7 give 0, codes 1 and 3 give all ones, and code 4 returns the operand. For a zero operand, codes 5, 6 and 8 give all ones.
- R7: `res_nobit` is 1 in two cases: the operand is all ones under codes 0 to 4 or 7, or the operand is zero under codes 5, 6 or 8. In every other case it is 0.
- R8: Codes 9 to 15 give a result of 0, `res_nobit` of 0 and `res_badop` of 1. `res_badop` is 0 for codes 0 to 8.
- R9: A cycle with `op_valid` low leaves `res_data`, `res_nobit` and `res_badop` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operand and code are presented this cycle |
| op_code | input | 4 | Transform select, 0 to 8 legal |
| op_x | input | 64 | Source operand |
| res_valid | output | 1 | Result strobe, one cycle after op_valid |
| res_data | output | 64 | Transform result |
| res_nobit | output | 1 | Operand had no qualifying bit |
| res_badop | output | 1 | Unused operation code |

## Verification
The unit's only state is the output register stage. A wrong value captured there shows at the ports on the cycle after the operand is offered, and it persists through every idle cycle that follows. So a corrupted capture or a missing hold is seen either at once or on the next idle cycle. A wrong carry into the increment or decrement mostly shows on the all-ones and all-zeros operands, where the flag and the result must change together. The bench drives those corners for every code, along with random operands and codes, and compares all outputs on every cycle.

// File: rtl/trailbit_pkg.sv
package trailbit_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_CLRFILL   = 4'd0;
    localparam logic [OP_W-1:0] OP_CLRHOLE   = 4'd1;
    localparam logic [OP_W-1:0] OP_CLRPICK   = 4'd2;
    localparam logic [OP_W-1:0] OP_CLRMASK   = 4'd3;
    localparam logic [OP_W-1:0] OP_CLRSET    = 4'd4;
    localparam logic [OP_W-1:0] OP_SETFILL   = 4'd5;
    localparam logic [OP_W-1:0] OP_SETHOLE   = 4'd6;
    localparam logic [OP_W-1:0] OP_ONESMASKN = 4'd7;
    localparam logic [OP_W-1:0] OP_ZEROMASK  = 4'd8;

    typedef struct packed {
        logic nobit;
        logic badop;
    } tb_flags_t;

    function automatic logic op_is_legal(input logic [OP_W-1:0] op);
        return op <= OP_ZEROMASK;
    endfunction

    function automatic logic op_uses_dec(input logic [OP_W-1:0] op);
        return (op == OP_SETFILL) || (op == OP_SETHOLE) || (op == OP_ZEROMASK);
    endfunction

endpackage

// File: rtl/trailbit_neighbors.sv
module trailbit_neighbors #(
    parameter int W = 64
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] x_inc,
    output logic [W-1:0] x_dec,
    output logic         all_ones,
    output logic         all_zero
);
    assign x_inc    = x + W'(1);
    assign x_dec    = x - W'(1);
    assign all_ones = &x;
    assign all_zero = ~|x;
endmodule

// File: rtl/trailbit_select.sv
module trailbit_select
    import trailbit_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    x,
    input  logic [W-1:0]    x_inc,
    input  logic [W-1:0]    x_dec,
    input  logic            all_ones,
    input  logic            all_zero,
    output logic [W-1:0]    res,
    output tb_flags_t       flags
);
    always_comb begin
        res = '0;
        unique case (op)
            OP_CLRFILL:   res = x & x_inc;
            OP_CLRHOLE:   res = x | ~x_inc;
            OP_CLRPICK:   res = ~x & x_inc;
            OP_CLRMASK:   res = x ^ x_inc;
            OP_CLRSET:    res = x | x_inc;
            OP_SETFILL:   res = x | x_dec;
            OP_SETHOLE:   res = ~x | x_dec;
            OP_ONESMASKN: res = ~x | x_inc;
            OP_ZEROMASK:  res = ~x & x_dec;
            default:      res = '0;
        endcase
    end

    always_comb begin
        flags.badop = !op_is_legal(op);
        if (!op_is_legal(op))
            flags.nobit = 1'b0;
        else if (op_uses_dec(op))
            flags.nobit = all_zero;
        else
            flags.nobit = all_ones;
    end
endmodule

// File: rtl/trailbit_unit.sv
module trailbit_unit
    import trailbit_pkg::*;
#(
    parameter int W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic [W-1:0]    op_x,
    output logic            res_valid,
    output logic [W-1:0]    res_data,
    output logic            res_nobit,
    output logic            res_badop
);
    logic [W-1:0] x_inc, x_dec, nxt_res;
    logic         all_ones, all_zero;
    tb_flags_t    nxt_flags, flags_q;

    trailbit_neighbors #(.W(W)) u_nbr (
        .x(op_x), .x_inc(x_inc), .x_dec(x_dec),
        .all_ones(all_ones), .all_zero(all_zero)
    );

    trailbit_select #(.W(W)) u_sel (
        .op(op_code), .x(op_x), .x_inc(x_inc), .x_dec(x_dec),
        .all_ones(all_ones), .all_zero(all_zero),
        .res(nxt_res), .flags(nxt_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            flags_q   <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_data <= nxt_res;
                flags_q  <= nxt_flags;
            end
        end
    end

    assign res_nobit = flags_q.nobit;
    assign res_badop = flags_q.badop;

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> res_valid == $past(op_valid));

    p_clrfill_subset_r2: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_CLRFILL |=> (res_data & ~$past(op_x)) == '0);

    p_pick_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_CLRPICK |=> $onehot0(res_data));

    p_nobit_inc_r7: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code <= OP_ZEROMASK && !op_uses_dec(op_code) && (&op_x)
        |=> res_nobit);

    p_badop_r8: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code > OP_ZEROMASK
        |=> res_badop && !res_nobit && res_data == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(res_data) && $stable(res_nobit) && $stable(res_badop));
endmodule

// File: tb/trailbit_unit_bench.sv
`timescale 1ns/1ps
module trailbit_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [63:0] op_x;
    logic        res_valid;
    logic [63:0] res_data;
    logic        res_nobit;
    logic        res_badop;

    int n_checks = 0;
    int n_fail   = 0;

    logic        e_valid;
    logic [63:0] e_data;
    logic        e_nobit;
    logic        e_badop;
    string       e_tag;

    always #2.5 clk = ~clk;

    trailbit_unit u_trailbit_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_x(op_x),
        .res_valid(res_valid), .res_data(res_data),
        .res_nobit(res_nobit), .res_badop(res_badop)
    );

    function automatic int low_zero(input logic [63:0] v);
        for (int i = 0; i < 64; i++) if (!v[i]) return i;
        return 64;
    endfunction

    function automatic int low_one(input logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return 64;
    endfunction

    function automatic logic [63:0] below(input int k);
        if (k >= 64) return '1;
        return (64'd1 << k) - 64'd1;
    endfunction

    function automatic logic [63:0] bitat(input int k);
        if (k >= 64) return '0;
        return 64'd1 << k;
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        if (op <= 4'd2) return "R2";
        if (op <= 4'd4) return "R3";
        if (op <= 4'd6) return "R4";
        if (op <= 4'd8) return "R5";
        return "R8";
    endfunction

    task automatic model(input logic [3:0] op, input logic [63:0] x,
                         output logic [63:0] r, output logic nb, output logic bo);
        int lz = low_zero(x);
        int lo = low_one(x);
        bo = 1'b0;
        nb = 1'b0;
        case (op)
            4'd0: begin r = x & ~below(lz);      nb = (lz == 64); end
            4'd1: begin r = ~bitat(lz);          nb = (lz == 64); end
            4'd2: begin r = bitat(lz);           nb = (lz == 64); end
            4'd3: begin r = below(lz) | bitat(lz); nb = (lz == 64); end
            4'd4: begin r = x | bitat(lz);       nb = (lz == 64); end
            4'd5: begin r = x | below(lo);       nb = (lo == 64); end
            4'd6: begin r = ~bitat(lo);          nb = (lo == 64); end
            4'd7: begin r = ~below(lz);          nb = (lz == 64); end
            4'd8: begin r = below(lo);           nb = (lo == 64); end
            default: begin r = '0; bo = 1'b1; end
        endcase
    endtask

    task automatic check_outputs();
        n_checks++;
        if (res_valid !== e_valid) begin
            n_fail++;
            $display("FAIL R1 res_valid actual=%0b expected=%0b", res_valid, e_valid);
        end
        n_checks++;
        if (res_data !== e_data) begin
            n_fail++;
            $display("FAIL %s res_data actual=%h expected=%h", e_tag, res_data, e_data);
        end
        n_checks++;
        if (res_nobit !== e_nobit) begin
            n_fail++;
            $display("FAIL R7 (%s) res_nobit actual=%0b expected=%0b", e_tag, res_nobit, e_nobit);
        end
        n_checks++;
        if (res_badop !== e_badop) begin
            n_fail++;
            $display("FAIL R8 (%s) res_badop actual=%0b expected=%0b", e_tag, res_badop, e_badop);
        end
    endtask

    // Check what the previous cycle produced, then drive the next one.
    task automatic step(input logic v, input logic [3:0] op, input logic [63:0] x,
                        input string tag);
        logic [63:0] r;
        logic nb, bo;
        @(negedge clk);
        check_outputs();
        op_valid = v;
        op_code  = op;
        op_x     = x;
        e_valid  = v;
        if (v) begin
            model(op, x, r, nb, bo);
            e_data  = r;
            e_nobit = nb;
            e_badop = bo;
            e_tag   = (tag == "") ? op_tag(op) : tag;
        end else begin
            e_tag = "R9";
        end
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; op_x = '0;
        e_valid = 1'b0; e_data = '0; e_nobit = 1'b0; e_badop = 1'b0; e_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state is checked by the first step
        step(1'b0, 4'd0, 64'h0, "R1");
        // Example vectors (R2, R5)
        step(1'b1, 4'd0, 64'h57, "R2");
        step(1'b1, 4'd2, 64'h51, "R2");
        step(1'b1, 4'd8, 64'h58, "R5");
        // Hold across idle with junk inputs (R9)
        step(1'b0, 4'd3, 64'hdead_beef_0000_1234, "");
        step(1'b0, 4'd12, 64'hffff_ffff_ffff_ffff, "");
        // Corner operands for every code (R6, R7)
        for (int op = 0; op < 9; op++) begin
            step(1'b1, 4'(op), 64'hffff_ffff_ffff_ffff, "R6");
            step(1'b1, 4'(op), 64'h0, "R6");
            step(1'b1, 4'(op), 64'h7fff_ffff_ffff_ffff, "");
            step(1'b1, 4'(op), 64'h8000_0000_0000_0000, "");
        end
        // Unused codes (R8)
        for (int op = 9; op < 16; op++) begin
            step(1'b1, 4'(op), 64'h0123_4567_89ab_cdef, "R8");
            step(1'b0, 4'd0, 64'h0, "");
        end
        // Random mix including idle cycles (R2..R5, R9)
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] rx;
            rx = {$urandom(), $urandom()};
            if ((i % 5) == 0) rx = rx | 64'hffff;
            if ((i % 7) == 0) rx = rx & 64'hffff_ffff_ffff_0000;
            step(($urandom() % 4) != 0, 4'($urandom_range(0, 15)), rx, "");
        end
        step(1'b0, 4'd0, 64'h0, "");
        @(negedge clk);
        check_outputs();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule